// File: doc/BRIEF.md
# Multichannel ADC Result Scaler

This block turns raw 16-bit converter samples into calibrated measurement codes for four monitor channels that a converter visits in round-robin order. Channel 0 carries the supply voltage and channels 1 to 3 are general monitor inputs. A sample comes in with a 2-bit channel index and a valid strobe. The block multiplies the sample by that channel's gain and adds that channel's signed offset. Monitor channels then get an arithmetic right shift. The result is clamped to the legal code range, its three low bits are cleared, and it is stored in the channel's measurement register.

Configuration is written one register at a time through a small write port. The port carries a channel index, a field select and a 16-bit data word. Every channel keeps its own gain and offset, so each can be calibrated on its own. The shift is applied in every mode, including the sweeps run while a channel is being calibrated. The host reads a measurement register by placing a channel index on the read port, and the stored value for that channel appears on the data output combinationally.

Top module: `adc_scaler`

## Requirements
- R1: After reset every measurement register holds 0000h. Every gain is 8000h (unity), every offset is 0000h and every shift is 0.
- R2: The gain is an unsigned 1.15 fraction. The scaled value is floor(sample × gain / 2^15), kept at 17 bits so that gains above unity do not wrap.
- R3: The offset is a signed 16-bit two's complement value. It is added to the scaled value after the gain step.
- R4: On channels 1 to 3, an arithmetic right shift of 0 to 7 places is applied after the offset and before saturation. The shift is taken from bits [2:0] of a shift write.
- R5: Channel 0 always uses a shift of zero, and shift writes addressed to channel 0 have no effect.
- R6: A shifted value above FFF8h is stored as FFF8h.
- R7: A shifted value below zero is stored as 0000h.
- R8: Bits [2:0] of every stored measurement are zero.
- R9: The measurement register of the strobed channel updates at the rising edge that samples the strobe. No other register changes at that edge, and no register changes when there is no strobe.
- R10: The field select is encoded as 0 for gain, 1 for offset, 2 for shift and 3 for reserved. Writes with select 3 change nothing.
- R11: A sample of 0000h with an offset of zero or less produces 0000h.
- R12: The read data output shows the measurement register picked by the read channel index in the same cycle.
- R13: A configuration write in the same cycle as a sample on that channel does not affect that sample. The new value applies from the next sample onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_valid_i | input | 1 | Sample strobe |
| smp_chan_i | input | 2 | Channel index of the sample |
| smp_data_i | input | 16 | Raw converter sample |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_chan_i | input | 2 | Channel index of the write |
| cfg_sel_i | input | 2 | Field select: 0 gain, 1 offset, 2 shift, 3 reserved |
| cfg_wdata_i | input | 16 | Configuration write data |
| rd_chan_i | input | 2 | Read channel index |
| rd_data_o | output | 16 | Selected measurement register |

## Verification
Some properties are checked on every cycle: stored codes never go above FFF8h and never have a low bit set, registers hold their value when no strobe arrives, and a null sample with a non-positive offset stores zero. The arithmetic itself can only be shown by the bench's scenarios. Those cover gain rounding, signed offsets, shift depth per channel, the channel 0 shift being ignored, the reserved select, and a configuration write in the same cycle as a sample. A behavioural reference model follows every strobe and write and compares the read port on every clock.

// File: rtl/adc_scaler_pkg.sv
package adc_scaler_pkg;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned N_CHAN    = 4;
  localparam int unsigned SHIFT_W   = 3;
  localparam int unsigned GAIN_FRAC = 15;
  localparam int unsigned LSB_ZERO  = 3;

  typedef enum logic [1:0] {
    SEL_GAIN   = 2'd0,
    SEL_OFFSET = 2'd1,
    SEL_SHIFT  = 2'd2,
    SEL_RSVD   = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/adc_scaler_cfg.sv
module adc_scaler_cfg
  import adc_scaler_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NC   = N_CHAN,
  parameter int unsigned SW   = SHIFT_W,
  parameter int unsigned GF   = GAIN_FRAC,
  localparam int unsigned CW  = $clog2(NC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [CW-1:0]              chan_i,
  input  logic [1:0]                 sel_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NC-1:0][DW-1:0]      gain_o,
  output logic [NC-1:0][DW-1:0]      off_o,
  output logic [NC-1:0][SW-1:0]      shift_o
);
  localparam logic [DW-1:0] GAIN_UNITY = DW'(1) << GF;

  cfg_sel_e sel;
  assign sel = cfg_sel_e'(sel_i);

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic hit;
    assign hit = we_i && (chan_i == CW'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        gain_o[c] <= GAIN_UNITY;
        off_o[c]  <= '0;
      end else if (hit) begin
        if (sel == SEL_GAIN)   gain_o[c] <= wdata_i;
        if (sel == SEL_OFFSET) off_o[c]  <= wdata_i;
      end
    end

    if (c == 0) begin : g_fixed
      // supply channel: shift not configurable
      assign shift_o[c] = '0;
    end else begin : g_prog
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       shift_o[c] <= '0;
        else if (hit && sel == SEL_SHIFT)  shift_o[c] <= wdata_i[SW-1:0];
      end
    end
  end
endmodule

// File: rtl/adc_scaler_dp.sv
module adc_scaler_dp
  import adc_scaler_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SW  = SHIFT_W,
  parameter int unsigned GF  = GAIN_FRAC,
  parameter int unsigned LZ  = LSB_ZERO
) (
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] gain_i,
  input  logic [DW-1:0] off_i,
  input  logic [SW-1:0] shift_i,
  output logic [DW-1:0] res_o
);
  localparam int unsigned PW  = 2 * DW;
  localparam int unsigned SCW = PW - GF;
  localparam int unsigned SMW = SCW + 2;
  localparam logic [DW-1:0] FS_CODE = {{(DW-LZ){1'b1}}, {LZ{1'b0}}};

  logic [PW-1:0]         prod;
  logic [SCW-1:0]        scaled;
  logic signed [SMW-1:0] sum;
  logic signed [SMW-1:0] shifted;

  assign prod    = PW'(smp_i) * PW'(gain_i);
  assign scaled  = SCW'(prod >> GF);
  assign sum     = $signed({2'b00, scaled}) +
                   $signed({{(SMW-DW){off_i[DW-1]}}, off_i});
  assign shifted = sum >>> shift_i;

  always_comb begin
    if (shifted[SMW-1])
      res_o = '0;
    else if (shifted > $signed({{(SMW-DW){1'b0}}, FS_CODE}))
      res_o = FS_CODE;
    else
      res_o = shifted[DW-1:0] & FS_CODE;
  end
endmodule

// File: rtl/adc_scaler_meas.sv
module adc_scaler_meas
  import adc_scaler_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NC  = N_CHAN,
  localparam int unsigned CW = $clog2(NC)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ld_i,
  input  logic [CW-1:0]         ld_chan_i,
  input  logic [DW-1:0]         ld_data_i,
  input  logic [CW-1:0]         rd_chan_i,
  output logic [DW-1:0]         rd_data_o,
  output logic [NC-1:0][DW-1:0] meas_o
);
  for (genvar c = 0; c < NC; c++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               meas_o[c] <= '0;
      else if (ld_i && ld_chan_i == CW'(c))      meas_o[c] <= ld_data_i;
    end
  end

  assign rd_data_o = meas_o[rd_chan_i];
endmodule

// File: rtl/adc_scaler.sv
module adc_scaler
  import adc_scaler_pkg::*;
#(
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned NC  = N_CHAN,
  parameter int unsigned SW  = SHIFT_W,
  parameter int unsigned GF  = GAIN_FRAC,
  parameter int unsigned LZ  = LSB_ZERO,
  localparam int unsigned CW = $clog2(NC)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_valid_i,
  input  logic [CW-1:0] smp_chan_i,
  input  logic [DW-1:0] smp_data_i,
  input  logic          cfg_we_i,
  input  logic [CW-1:0] cfg_chan_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_wdata_i,
  input  logic [CW-1:0] rd_chan_i,
  output logic [DW-1:0] rd_data_o
);
  logic [NC-1:0][DW-1:0] gain_q;
  logic [NC-1:0][DW-1:0] off_q;
  logic [NC-1:0][SW-1:0] shift_q;
  logic [NC-1:0][DW-1:0] meas_q;
  logic [DW-1:0]         result;

  adc_scaler_cfg #(.DW(DW), .NC(NC), .SW(SW), .GF(GF)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .chan_i  (cfg_chan_i),
    .sel_i   (cfg_sel_i),
    .wdata_i (cfg_wdata_i),
    .gain_o  (gain_q),
    .off_o   (off_q),
    .shift_o (shift_q)
  );

  // config is registered: a same-cycle write affects the next sample only
  adc_scaler_dp #(.DW(DW), .SW(SW), .GF(GF), .LZ(LZ)) u_dp (
    .smp_i   (smp_data_i),
    .gain_i  (gain_q[smp_chan_i]),
    .off_i   (off_q[smp_chan_i]),
    .shift_i (shift_q[smp_chan_i]),
    .res_o   (result)
  );

  adc_scaler_meas #(.DW(DW), .NC(NC)) u_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_i      (smp_valid_i),
    .ld_chan_i (smp_chan_i),
    .ld_data_i (result),
    .rd_chan_i (rd_chan_i),
    .rd_data_o (rd_data_o),
    .meas_o    (meas_q)
  );
endmodule

// File: rtl/adc_scaler_chk.sv
module adc_scaler_chk #(
  parameter int unsigned DW  = 16,
  parameter int unsigned NC  = 4,
  parameter int unsigned LZ  = 3,
  localparam int unsigned CW = $clog2(NC)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  smp_valid_i,
  input logic [CW-1:0]         smp_chan_i,
  input logic [DW-1:0]         smp_data_i,
  input logic [CW-1:0]         rd_chan_i,
  input logic [DW-1:0]         rd_data_o,
  input logic [NC-1:0][DW-1:0] off_i,
  input logic [NC-1:0][DW-1:0] meas_i
);
  localparam logic [DW-1:0] FS_CODE = {{(DW-LZ){1'b1}}, {LZ{1'b0}}};

  AST_FS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o <= FS_CODE); // R6

  AST_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[LZ-1:0] == '0); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(rd_chan_i) -> $stable(rd_data_o))); // R9

  AST_NULL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && smp_data_i == '0 &&
    (off_i[smp_chan_i] == '0 || off_i[smp_chan_i][DW-1])
    |=> meas_i[$past(smp_chan_i)] == '0); // R11

  AST_READ_MUX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o == meas_i[rd_chan_i]); // R12
endmodule

bind adc_scaler adc_scaler_chk #(.DW(DW), .NC(NC), .LZ(LZ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .smp_valid_i (smp_valid_i),
  .smp_chan_i  (smp_chan_i),
  .smp_data_i  (smp_data_i),
  .rd_chan_i   (rd_chan_i),
  .rd_data_o   (rd_data_o),
  .off_i       (off_q),
  .meas_i      (meas_q)
);

// File: tb/tb_adc_scaler.sv
module tb_adc_scaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic [1:0]  smp_chan = '0;
  logic [15:0] smp_data = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  rd_chan = '0;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;
  longint m_gain[4];
  longint m_off[4];
  longint m_sh[4];
  longint m_meas[4];

  always #5 clk = ~clk;

  adc_scaler dut (
    .clk_i(clk), .rst_ni(rst_n),
    .smp_valid_i(smp_valid), .smp_chan_i(smp_chan), .smp_data_i(smp_data),
    .cfg_we_i(cfg_we), .cfg_chan_i(cfg_chan), .cfg_sel_i(cfg_sel),
    .cfg_wdata_i(cfg_wdata), .rd_chan_i(rd_chan), .rd_data_o(rd_data)
  );

  function automatic longint ref_calc(longint d, longint g, longint o, longint s);
    longint v;
    v = (d * g) >>> 15;
    v = v + ((o >= 32768) ? o - 65536 : o);
    v = v >>> s;
    if (v < 0) return 0;
    if (v > 65528) return 65528;
    return v & 64'hFFF8;
  endfunction

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model: results use config as it stood before this edge
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_gain[c] = 32768; m_off[c] = 0; m_sh[c] = 0; m_meas[c] = 0;
      end
    end else begin
      if (smp_valid)
        m_meas[smp_chan] = ref_calc(longint'(smp_data), m_gain[smp_chan],
                                    m_off[smp_chan], m_sh[smp_chan]);
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: m_gain[cfg_chan] = longint'(cfg_wdata);
          2'd1: m_off[cfg_chan]  = longint'(cfg_wdata);
          2'd2: if (cfg_chan != 0) m_sh[cfg_chan] = longint'(cfg_wdata[2:0]);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of the read port against the model
  always @(posedge clk) begin
    if (rst_n) begin
      #3;
      check("R12 model", longint'(rd_data), m_meas[rd_chan]);
    end
  end

  task automatic smp(input logic [1:0] c, input logic [15:0] d);
    @(negedge clk); smp_valid = 1; smp_chan = c; smp_data = d;
    @(negedge clk); smp_valid = 0;
  endtask

  task automatic cfg(input logic [1:0] c, input logic [1:0] s, input logic [15:0] d);
    @(negedge clk); cfg_we = 1; cfg_chan = c; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(input logic [1:0] c, output logic [15:0] v);
    @(negedge clk); rd_chan = c; #1; v = rd_data;
  endtask

  initial begin
    logic [15:0] v;
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < 4; c++) begin rd(2'(c), v); check("R1 reset meas", v, 0); end
        smp(1, 16'h1234); rd(1, v); check("R1 unity gain", v, 16'h1230);
        smp(0, 16'hFFFF); rd(0, v); check("R8 low bits", v, 16'hFFF8);
        cfg(2, 0, 16'h4000); smp(2, 16'h8000); rd(2, v); check("R2 half gain", v, 16'h4000);
        cfg(2, 0, 16'h6000); smp(2, 16'h0007); rd(2, v); check("R2 floor", v, 16'h0000);
        cfg(1, 1, 16'h0100); smp(1, 16'h1000); rd(1, v); check("R3 pos offset", v, 16'h1100);
        cfg(1, 1, 16'hFF00); smp(1, 16'h0100); rd(1, v); check("R7 neg clamp", v, 16'h0000);
        smp(1, 16'h0000); rd(1, v); check("R11 null", v, 16'h0000);
        cfg(3, 0, 16'hFFFF); smp(3, 16'hFFFF); rd(3, v); check("R6 sat", v, 16'hFFF8);
        cfg(3, 0, 16'h8000); cfg(3, 2, 16'hFFFB); smp(3, 16'h8000); rd(3, v);
        check("R4 shift3", v, 16'h1000);
        cfg(3, 2, 16'h0007); smp(3, 16'hFFFF); rd(3, v); check("R4 shift7", v, 16'h01F8);
        cfg(3, 1, 16'hFFF8); cfg(3, 2, 16'h0001); smp(3, 16'h0000); rd(3, v);
        check("R7 neg shift", v, 16'h0000);
        cfg(0, 2, 16'h0007); smp(0, 16'h8000); rd(0, v); check("R5 ch0 no shift", v, 16'h8000);
        cfg(2, 3, 16'h0000); smp(2, 16'h8000); rd(2, v); check("R10 rsvd ignored", v, 16'h6000);
        rd(1, v); check("R9 others hold", v, 16'h0000);
        // same-cycle write and sample on channel 0
        @(negedge clk);
        smp_valid = 1; smp_chan = 0; smp_data = 16'h2000;
        cfg_we = 1; cfg_chan = 0; cfg_sel = 0; cfg_wdata = 16'h4000;
        @(negedge clk); smp_valid = 0; cfg_we = 0;
        rd(0, v); check("R13 old cfg", v, 16'h2000);
        smp(0, 16'h2000); rd(0, v); check("R13 new cfg", v, 16'h1000);
        repeat (4) @(negedge clk);
        rd(0, v); check("R9 idle hold", v, 16'h1000);
        for (int i = 0; i < 200; i++) begin
          cfg(2'(i % 4), 2'((i / 4) % 4), 16'((i * 40503) ^ 16'h5A5A));
          smp(2'((i * 3) % 4), 16'(i * 7919));
          rd(2'(i % 4), v);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule